// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Burst Memory

This block is a synthesizable model of a synchronous single-port static memory. It can stand in for an external burst memory in a simulation environment or serve as a small on-chip store. Each enabled rising clock edge registers the address, the controls and the byte-lane enables. The write data for an access is taken one enabled edge later. Read data leaves the storage array combinationally from the registered address, with no output register, so it is valid in the cycle that follows the address edge.

An access is started by a load edge (`burst_adv` low) on which all three chip selects are active. Edges with `burst_adv` high continue the current access at the next address of a four-beat burst. The burst order is fixed at the load edge and is either linear or interleaved. Reads and writes may alternate on consecutive edges with no idle cycle between them. A clock-enable input freezes the whole block, and a synchronous reset returns it to the deselected state.

Top module: `nwsram_top`

## Requirements
- R1: While `rst` is high at a rising edge, the block becomes deselected regardless of `clk_en_n`. After that edge `dout_en` is 0, `dout` is 0, and a write whose data was due at that edge is dropped.
- R2: At a load edge (`clk_en_n` low, `burst_adv` low) with all chip selects active, a write begins when `rw_n` is 0 and a read begins when `rw_n` is 1. The address is taken from `addr`.
- R3: Write data for a beat whose address was registered at one enabled edge is taken from `din` at the next enabled edge, and the array is updated at that edge. `bw_n` is registered with the address and is active low: bit i allows the write of `din[i*LANE_W +: LANE_W]`. The other lanes keep their contents.
- R4: After an edge that registers a read beat, `dout_en` is 1 and `dout` shows the stored word at that beat's address in the same cycle. Whenever `dout_en` is 0, `dout` is 0.
- R5: A read may follow a write on the very next edge, and a write may follow a read. A read of the address whose write data is taken at that same edge returns the new data.
- R6: An enabled edge with `burst_adv` high, during an active access, advances the beat count by one and keeps the read/write type. In linear order (`mode_ilv` low at the load edge), the low two address bits are the start value plus the count, modulo 4. The upper address bits stay fixed.
- R7: In interleaved order (`mode_ilv` high at the load edge), the low two address bits are the start value XOR the count.
- R8: The beat count wraps after four beats, so the fifth beat addresses the same word as the first.
- R9: A load edge with `ce1_n` high, `ce2` low or `ce3_n` high is a deselect: nothing is written and `dout_en` is 0. Advance edges that follow a deselect leave the block deselected.
- R10: At a rising edge with `clk_en_n` high and `rst` low, no state and no array word changes, and the outputs hold. A write whose data is due completes at the next enabled edge, using `din` from that edge.
- R11: During a write beat, `dout_en` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Edge enable, active low; high freezes the block |
| burst_adv | input | 1 | Low: load a new access; high: advance the burst |
| rw_n | input | 1 | At a load edge: 1 read, 0 write |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| mode_ilv | input | 1 | At a load edge: 1 interleaved order, 0 linear order |
| addr | input | ADDR_W | Word address, taken at load edges |
| bw_n | input | LANES | Byte-lane write enables, active low |
| din | input | LANES*LANE_W | Write data, taken one enabled edge after its address |
| dout | output | LANES*LANE_W | Flow-through read data, 0 when not driving |
| dout_en | output | 1 | High while a read beat is presented |

## Verification
The assertions check on every cycle that reset leaves the output quiet, that a suspended edge holds both outputs, that a deselect or a write start never drives the output, that a read start always drives it, and that an advance edge keeps the read/write type. Only the bench's scenarios can show the data itself. These scenarios cover the beat addresses of the linear and interleaved orders, the wrap after four beats, the one-edge lag of write data and its completion across a suspend, lane-masked writes, and back-to-back read/write alternation on the same address. They also cover the dropping of a pending write by reset.

// File: rtl/nwsram_pkg.sv
package nwsram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits of a burst beat.
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input logic       ilv);
        return ilv ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/nwsram_seq.sv
module nwsram_seq
    import nwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              burst_adv,
    input  logic              rw_n,
    input  logic              sel_ok,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bw_n,
    output op_e               op_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [1:0]        cnt_o,
    output logic              ilv_o,
    output logic [LANES-1:0]  lane_we
);

    typedef struct packed {
        op_e              op;
        logic             ilv;
        logic [ADDR_W-1:0] base;
        logic [1:0]       cnt;
        logic [LANES-1:0] bw_n;
    } seq_t;

    seq_t st_d, st_q;
    logic wr_fire;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d    = '0;
            st_d.op = OP_IDLE;
        end else if (!clk_en_n) begin
            if (!burst_adv) begin
                // load edge: new access or deselect
                st_d.op   = !sel_ok ? OP_IDLE : (rw_n ? OP_READ : OP_WRITE);
                st_d.ilv  = mode_ilv;
                st_d.base = addr;
                st_d.cnt  = '0;
                st_d.bw_n = bw_n;
            end else if (st_q.op != OP_IDLE) begin
                // advance edge: next beat of the same access
                st_d.cnt  = st_q.cnt + 2'd1;
                st_d.bw_n = bw_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // The registered write beat consumes din at the next enabled edge.
    assign wr_fire = !rst && !clk_en_n && (st_q.op == OP_WRITE);
    assign lane_we = wr_fire ? ~st_q.bw_n : '0;

    assign op_o   = st_q.op;
    assign base_o = st_q.base;
    assign cnt_o  = st_q.cnt;
    assign ilv_o  = st_q.ilv;

endmodule

// File: rtl/nwsram_burst.sv
module nwsram_burst
    import nwsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        cnt,
    input  logic              ilv,
    output logic [ADDR_W-1:0] beat_addr
);

    // Upper bits stay fixed for the whole burst; only the low pair moves.
    assign beat_addr = {base[ADDR_W-1:2], beat_low(base[1:0], cnt, ilv)};

endmodule

// File: rtl/nwsram_array.sv
module nwsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/nwsram_top.sv
module nwsram_top
    import nwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_en_n,
    input  logic                    burst_adv,
    input  logic                    rw_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    mode_ilv,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DATA_W = LANES * LANE_W;

    op_e               op;
    logic [ADDR_W-1:0] base;
    logic [1:0]        cnt;
    logic              ilv;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] beat_addr;
    logic [DATA_W-1:0] rdata;
    logic              sel_ok;

    assign sel_ok = !ce1_n && ce2 && !ce3_n;

    nwsram_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .clk_en_n  (clk_en_n),
        .burst_adv (burst_adv),
        .rw_n      (rw_n),
        .sel_ok    (sel_ok),
        .mode_ilv  (mode_ilv),
        .addr      (addr),
        .bw_n      (bw_n),
        .op_o      (op),
        .base_o    (base),
        .cnt_o     (cnt),
        .ilv_o     (ilv),
        .lane_we   (lane_we)
    );

    nwsram_burst #(.ADDR_W(ADDR_W)) i_burst (
        .base      (base),
        .cnt       (cnt),
        .ilv       (ilv),
        .beat_addr (beat_addr)
    );

    nwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
        .clk     (clk),
        .lane_we (lane_we),
        .addr    (beat_addr),
        .wdata   (din),
        .rdata   (rdata)
    );

    // Flow-through: no register between the array and the output.
    assign dout_en = (op == OP_READ);
    assign dout    = dout_en ? rdata : '0;

endmodule

// File: rtl/nwsram_chk.sv
module nwsram_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en_n,
    input logic              burst_adv,
    input logic              rw_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    logic sel_all;
    assign sel_all = !ce1_n && ce2 && !ce3_n;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!dout_en && dout == '0));

    assert_read_drives_R4: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !burst_adv && sel_all && rw_n) |=> dout_en);

    assert_write_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !burst_adv && sel_all && !rw_n) |=> (!dout_en && dout == '0));

    assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !burst_adv && !sel_all) |=> !dout_en);

    assert_advance_keeps_type_R6: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && burst_adv) |=> (dout_en == $past(dout_en)));

    assert_suspend_holds_R10: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(dout) && $stable(dout_en)));

endmodule

bind nwsram_top nwsram_chk #(.DATA_W(LANES * LANE_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_en_n  (clk_en_n),
    .burst_adv (burst_adv),
    .rw_n      (rw_n),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .dout      (dout),
    .dout_en   (dout_en)
);

// File: tb/test_nwsram_top.sv
`timescale 1ns/1ps
module test_nwsram_top;

    localparam int AW = 6;
    localparam int NL = 2;
    localparam int LW = 9;
    localparam int W  = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst, clk_en_n, burst_adv, rw_n, ce1_n, ce2, ce3_n, mode_ilv;
    logic [AW-1:0] addr;
    logic [NL-1:0] bw_n;
    logic [W-1:0]  din, dout;
    logic          dout_en;

    int n_cmp = 0;
    int n_bad = 0;
    int ce_sel = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_mem [DEPTH];

    always #2.5 clk = ~clk;

    nwsram_top #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_nwsram_top (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .burst_adv(burst_adv),
        .rw_n(rw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .mode_ilv(mode_ilv), .addr(addr), .bw_n(bw_n), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    function automatic int baddr(input int base, input int k, input bit ilv);
        int lo;
        lo = ilv ? ((base & 3) ^ (k & 3)) : (((base & 3) + k) % 4);
        return (base & ~3) | lo;
    endfunction

    function automatic logic [W-1:0] pat(input int a, input int salt);
        return W'((a * 37 + salt * 1013 + 5) % (1 << W));
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input bit wr, input int a, input bit ilv,
                        input logic [NL-1:0] bwn, input logic [W-1:0] d);
        clk_en_n  = 1'b0;
        burst_adv = 1'b0;
        rw_n      = !wr;
        addr      = AW'(a);
        mode_ilv  = ilv;
        bw_n      = bwn;
        din       = d;
        ce1_n     = (ce_sel == 1);
        ce2       = (ce_sel != 2);
        ce3_n     = (ce_sel == 3);
        step();
    endtask

    task automatic adv(input logic [NL-1:0] bwn, input logic [W-1:0] d);
        clk_en_n  = 1'b0;
        burst_adv = 1'b1;
        bw_n      = bwn;
        din       = d;
        addr      = ~addr;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog got %0d exp %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] carry, held, oldv, newv;
        int last_a, base, a;
        bit ilv;

        rst = 1'b1; clk_en_n = 1'b0; burst_adv = 1'b0; rw_n = 1'b1;
        ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1; mode_ilv = 1'b0;
        addr = '0; bw_n = '0; din = '0;
        step(); step();
        // R1: reset state
        chk("R1 reset dout_en", W'(dout_en), W'(0));
        chk("R1 reset dout", dout, '0);
        rst = 1'b0;

        // R2/R3/R6/R7: fill every word with write bursts, back to back
        carry = '0;
        last_a = 0;
        for (int g = 0; g < DEPTH / 4; g++) begin
            base = g * 4 + (g % 4);
            ilv  = g[0];
            load(1'b1, base, ilv, 2'b00, carry);
            chk("R11 write beat quiet", {dout[W-1:1], dout_en}, '0);
            for (int k = 1; k < 4; k++) begin
                adv(2'b00, pat(baddr(base, k - 1, ilv), 0));
            end
            for (int k = 0; k < 4; k++) exp_mem[baddr(base, k, ilv)] = pat(baddr(base, k, ilv), 0);
            carry  = pat(baddr(base, 3, ilv), 0);
            last_a = baddr(base, 3, ilv);
        end
        // R5: read the word whose data is taken at this same edge
        load(1'b0, last_a, 1'b0, 2'b11, carry);
        chk("R5 write-then-read", dout, exp_mem[last_a]);

        // R4/R6/R7/R8: read back every word in the opposite order, plus wrap
        for (int g = 0; g < DEPTH / 4; g++) begin
            base = g * 4 + ((g + 1) % 4);
            ilv  = !g[0];
            load(1'b0, base, ilv, 2'b11, '0);
            chk("R4 read drive", W'(dout_en), W'(1));
            chk(ilv ? "R7 beat0" : "R6 beat0", dout, exp_mem[baddr(base, 0, ilv)]);
            for (int k = 1; k < 4; k++) begin
                adv(2'b11, '0);
                chk(ilv ? "R7 interleaved beat" : "R6 linear beat", dout, exp_mem[baddr(base, k, ilv)]);
            end
            adv(2'b11, '0);
            chk("R8 wrap to first beat", dout, exp_mem[baddr(base, 0, ilv)]);
        end

        // R5: read then write then read of one word with no gaps
        load(1'b0, 10, 1'b0, 2'b11, '0);
        chk("R5 read before write", dout, exp_mem[10]);
        load(1'b1, 10, 1'b0, 2'b00, '0);
        chk("R11 write after read quiet", W'(dout_en), W'(0));
        newv = 18'h2A5C3;
        load(1'b0, 10, 1'b0, 2'b11, newv);
        exp_mem[10] = newv;
        chk("R5 read after write", dout, exp_mem[10]);

        // R3: lane-masked writes (bw_n bit 0 -> bits 8:0, bit 1 -> bits 17:9)
        newv = 18'h15A96;
        load(1'b1, 20, 1'b0, 2'b10, '0);
        load(1'b0, 20, 1'b0, 2'b11, newv);
        exp_mem[20] = {exp_mem[20][17:9], newv[8:0]};
        chk("R3 lane0 only", dout, exp_mem[20]);
        newv = 18'h0F0F1;
        load(1'b1, 20, 1'b0, 2'b01, '0);
        load(1'b0, 20, 1'b0, 2'b11, newv);
        exp_mem[20] = {newv[17:9], exp_mem[20][8:0]};
        chk("R3 lane1 only", dout, exp_mem[20]);

        // R9: each chip select on its own causes a deselect
        for (int s = 1; s <= 3; s++) begin
            ce_sel = s;
            load(1'b1, 30, 1'b0, 2'b00, '0);
            chk("R9 deselect quiet", W'(dout_en), W'(0));
            adv(2'b00, 18'h3FFFF);
            chk("R9 advance stays deselected", W'(dout_en), W'(0));
            adv(2'b00, 18'h3FFFF);
            ce_sel = 0;
            load(1'b0, 30, 1'b0, 2'b11, 18'h3FFFF);
            chk("R9 no write at 30", dout, exp_mem[30]);
            adv(2'b11, '0);
            chk("R9 no write at 31", dout, exp_mem[31]);
        end

        // R10: suspend in the middle of a read burst
        load(1'b0, 40, 1'b0, 2'b11, '0);
        held = dout;
        chk("R10 before suspend", held, exp_mem[40]);
        for (int i = 0; i < 3; i++) begin
            clk_en_n = 1'b1; burst_adv = 1'b1; addr = AW'(i * 7); din = pat(i, 9);
            step();
            chk("R10 held during suspend", dout, held);
        end
        adv(2'b11, '0);
        chk("R10 resume next beat", dout, exp_mem[41]);

        // R10: pending write completes after a suspend with the later din
        load(1'b1, 44, 1'b0, 2'b00, '0);
        for (int i = 0; i < 2; i++) begin
            clk_en_n = 1'b1; din = 18'h3FFFF; step();
        end
        newv = 18'h1C3A7;
        load(1'b0, 44, 1'b0, 2'b11, newv);
        exp_mem[44] = newv;
        chk("R10 write after suspend", dout, exp_mem[44]);

        // R1: reset drops a write whose data is due
        oldv = exp_mem[50];
        load(1'b1, 50, 1'b0, 2'b00, '0);
        rst = 1'b1; clk_en_n = 1'b1; din = 18'h3FFFF;
        step();
        chk("R1 reset quiet", {dout[W-1:1], dout_en}, '0);
        rst = 1'b0;
        load(1'b0, 50, 1'b0, 2'b11, 18'h3FFFF);
        chk("R1 pending write dropped", dout, oldv);
        a = 51;
        load(1'b0, a, 1'b1, 2'b11, '0);
        chk("R2 read after reset", dout, exp_mem[a]);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule